// File: doc/BRIEF.md
# Display Controller Extended Timing Registers

This block holds the extension registers of a display CRT controller. Software writes them one byte at a time, each write carrying a register index and a data byte. The block takes five base timing values from the standard timing registers elsewhere in the controller. It returns the same five values with high-order offsets added for every extension bit that is set. The pixel counters and sync generators outside the block use these adjusted values.

A pixel-mode register holds five extension bits. Each bit adds 0x400 to one of the following: vertical total, vertical blank start, vertical sync start, horizontal display end or vertical display end. Bit 0 of a large-screen register adds a further 0x100 to horizontal display end. A GPIO register drives the clock and data lines of a two-wire serial bus. A write to any timing-relevant index raises a recalculation request for one cycle.

The request comes from a two-state machine. `RC_IDLE` is the rest state. A qualifying write in `RC_IDLE` takes the machine to `RC_PULSE`, where `recalc_o` is high. A qualifying write in `RC_PULSE` keeps it in `RC_PULSE`. Any other cycle in `RC_PULSE` returns it to `RC_IDLE`. The adjusted outputs are combinational sums of the stored bits and the base inputs. They change in the cycle that follows the write edge.

Top module: `crtcx_ext_top`

## Requirements
- R1: The pixel-mode register sits at index 0x25. While its bit 0 is set, `vtotal_o` equals `vtotal_base_i` + 0x400; otherwise it equals `vtotal_base_i`.
- R2: While pixel-mode bit 2 is set, `vblank_o` equals `vblank_base_i` + 0x400; otherwise it equals `vblank_base_i`.
- R3: While pixel-mode bit 3 is set, `vsync_o` equals `vsync_base_i` + 0x400; otherwise it equals `vsync_base_i`.
- R4: While pixel-mode bit 4 is set, 0x400 is added to `hdend_o` over `hdend_base_i`.
- R5: While pixel-mode bit 1 is set, `vdend_o` equals `vdend_base_i` + 0x400; otherwise it equals `vdend_base_i`.
- R6: The large-screen register sits at index 0x2D. While its bit 0 is set, 0x100 is added to `hdend_o`, on top of any R4 offset. The other bits of that register have no effect.
- R7: The GPIO register sits at index 0x3E. From the cycle after a write to it, `scl_o` follows data bit 5 and `sda_o` follows data bit 4.
- R8: A write whose index is below 0x0E or above 0x10 sets `recalc_o` high for exactly the next cycle. Indices 0x0E, 0x0F and 0x10 raise no request. Back-to-back qualifying writes keep `recalc_o` high one cycle per write.
- R9: After reset, every extension bit and both serial lines are 0, each output equals its base input, and `recalc_o` is low.
- R10: Writing the same pixel-mode value again adds no further offset. Writing 0 removes every offset.
- R11: A write to an index other than 0x25, 0x2D or 0x3E leaves the timing outputs and the serial lines unchanged.
- R12: Base-input changes appear on the outputs in the same cycle, with the stored offsets applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 8 | Register index of the write |
| wr_data_i | input | 8 | Write data byte |
| vtotal_base_i | input | 12 | Base vertical total |
| vblank_base_i | input | 12 | Base vertical blank start |
| vsync_base_i | input | 12 | Base vertical sync start |
| hdend_base_i | input | 12 | Base horizontal display end |
| vdend_base_i | input | 12 | Base vertical display end |
| vtotal_o | output | 12 | Adjusted vertical total |
| vblank_o | output | 12 | Adjusted vertical blank start |
| vsync_o | output | 12 | Adjusted vertical sync start |
| hdend_o | output | 12 | Adjusted horizontal display end |
| vdend_o | output | 12 | Adjusted vertical display end |
| scl_o | output | 1 | Serial bus clock line level |
| sda_o | output | 1 | Serial bus data line level |
| recalc_o | output | 1 | One-cycle timing recalculation request |

## Verification
The bench builds the block with its default parameters. These are a 12-bit timing width, register indices 0x25, 0x2D and 0x3E, the bit mapping listed in R1 to R5, and a recalculation window of 0x0E to 0x10. With a 12-bit width, the largest base value used (0x3FF) plus both offsets still fits without wrapping, so every sum can be checked exactly. The default window puts index 0x0D and index 0x11 on either side of the excluded indices. This lets the bench probe both edges of R8 and all three excluded indices.

// File: rtl/crtcx_pkg.sv
package crtcx_pkg;

    typedef enum logic [0:0] {
        RC_IDLE  = 1'b0,
        RC_PULSE = 1'b1
    } recalc_state_t;

    localparam int unsigned NUM_EXT = 5;

    // channel numbering of the adjusted timing values
    localparam int unsigned CH_VTOTAL = 0;
    localparam int unsigned CH_VBLANK = 1;
    localparam int unsigned CH_VSYNC  = 2;
    localparam int unsigned CH_HDEND  = 3;
    localparam int unsigned CH_VDEND  = 4;

endpackage

// File: rtl/crtcx_regfile.sv
module crtcx_regfile
    import crtcx_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned DATA_W    = 8,
    parameter logic [IDX_W-1:0] IDX_PIX   = 8'h25,
    parameter logic [IDX_W-1:0] IDX_LARGE = 8'h2D,
    parameter logic [IDX_W-1:0] IDX_GPIO  = 8'h3E,
    parameter int unsigned BIT_VTOTAL = 0,
    parameter int unsigned BIT_VDEND  = 1,
    parameter int unsigned BIT_VBLANK = 2,
    parameter int unsigned BIT_VSYNC  = 3,
    parameter int unsigned BIT_HDEND  = 4,
    parameter int unsigned BIT_LARGE  = 0,
    parameter int unsigned BIT_SCL    = 5,
    parameter int unsigned BIT_SDA    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [NUM_EXT-1:0] ext_o,
    output logic               large_o,
    output logic               scl_o,
    output logic               sda_o
);

    function automatic int unsigned chan_bit(input int unsigned ch);
        case (ch)
            CH_VTOTAL: chan_bit = BIT_VTOTAL;
            CH_VBLANK: chan_bit = BIT_VBLANK;
            CH_VSYNC:  chan_bit = BIT_VSYNC;
            CH_HDEND:  chan_bit = BIT_HDEND;
            default:   chan_bit = BIT_VDEND;
        endcase
    endfunction

    logic sel_pix, sel_large, sel_gpio;

    always_comb begin
        sel_pix   = wr_en_i && (wr_idx_i == IDX_PIX);
        sel_large = wr_en_i && (wr_idx_i == IDX_LARGE);
        sel_gpio  = wr_en_i && (wr_idx_i == IDX_GPIO);
    end

    // one stored bit per extension channel, taken from its own data position
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        localparam int unsigned POS = chan_bit(g);
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (sel_pix)
                bit_q <= wr_data_i[POS];
        end
        assign ext_o[g] = bit_q;
    end

    logic large_q, scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            large_q <= 1'b0;
            scl_q   <= 1'b0;
            sda_q   <= 1'b0;
        end else begin
            if (sel_large)
                large_q <= wr_data_i[BIT_LARGE];
            if (sel_gpio) begin
                scl_q <= wr_data_i[BIT_SCL];
                sda_q <= wr_data_i[BIT_SDA];
            end
        end
    end

    assign large_o = large_q;
    assign scl_o   = scl_q;
    assign sda_o   = sda_q;

    // R7: serial lines take the written bits on the following cycle
    assert_gpio_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_gpio |=> (scl_o == $past(wr_data_i[BIT_SCL])) && (sda_o == $past(wr_data_i[BIT_SDA])));

endmodule

// File: rtl/crtcx_recalc_fsm.sv
module crtcx_recalc_fsm
    import crtcx_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter logic [IDX_W-1:0] WIN_LO = 8'h0E,
    parameter logic [IDX_W-1:0] WIN_HI = 8'h10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    output logic             recalc_o
);

    recalc_state_t state_q, state_d;
    logic          hit;

    assign hit = wr_en_i && ((wr_idx_i < WIN_LO) || (wr_idx_i > WIN_HI));

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RC_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        recalc_o = 1'b0;
        unique case (state_q)
            RC_IDLE: begin
                if (hit) state_d = RC_PULSE;
            end
            RC_PULSE: begin
                recalc_o = 1'b1;
                state_d  = hit ? RC_PULSE : RC_IDLE;
            end
            default: state_d = RC_IDLE;
        endcase
    end

    // R8: a request only ever follows a write outside the excluded window
    assert_recalc_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_o |-> $past(wr_en_i) && (($past(wr_idx_i) < WIN_LO) || ($past(wr_idx_i) > WIN_HI)));

endmodule

// File: rtl/crtcx_timing_adj.sv
module crtcx_timing_adj
    import crtcx_pkg::*;
#(
    parameter int unsigned TIMING_W = 12,
    parameter int unsigned HI_OFS   = 1024,
    parameter int unsigned LS_OFS   = 256
) (
    input  logic [NUM_EXT-1:0][TIMING_W-1:0] base_i,
    input  logic [NUM_EXT-1:0]               ext_i,
    input  logic                             large_i,
    output logic [NUM_EXT-1:0][TIMING_W-1:0] adj_o
);

    localparam logic [TIMING_W-1:0] HI_V = TIMING_W'(HI_OFS);

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ch
        localparam logic [TIMING_W-1:0] LS_V = (g == CH_HDEND) ? TIMING_W'(LS_OFS) : '0;
        assign adj_o[g] = base_i[g] + (ext_i[g] ? HI_V : '0) + (large_i ? LS_V : '0);
    end

endmodule

// File: rtl/crtcx_ext_top.sv
module crtcx_ext_top
    import crtcx_pkg::*;
#(
    parameter int unsigned TIMING_W = 12,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned DATA_W   = 8,
    parameter logic [IDX_W-1:0] IDX_PIX   = 8'h25,
    parameter logic [IDX_W-1:0] IDX_LARGE = 8'h2D,
    parameter logic [IDX_W-1:0] IDX_GPIO  = 8'h3E,
    parameter logic [IDX_W-1:0] WIN_LO    = 8'h0E,
    parameter logic [IDX_W-1:0] WIN_HI    = 8'h10,
    parameter int unsigned BIT_VTOTAL = 0,
    parameter int unsigned BIT_VDEND  = 1,
    parameter int unsigned BIT_VBLANK = 2,
    parameter int unsigned BIT_VSYNC  = 3,
    parameter int unsigned BIT_HDEND  = 4,
    parameter int unsigned BIT_SCL    = 5,
    parameter int unsigned BIT_SDA    = 4,
    parameter int unsigned HI_OFS     = 1024,
    parameter int unsigned LS_OFS     = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [IDX_W-1:0]    wr_idx_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    input  logic [TIMING_W-1:0] vtotal_base_i,
    input  logic [TIMING_W-1:0] vblank_base_i,
    input  logic [TIMING_W-1:0] vsync_base_i,
    input  logic [TIMING_W-1:0] hdend_base_i,
    input  logic [TIMING_W-1:0] vdend_base_i,
    output logic [TIMING_W-1:0] vtotal_o,
    output logic [TIMING_W-1:0] vblank_o,
    output logic [TIMING_W-1:0] vsync_o,
    output logic [TIMING_W-1:0] hdend_o,
    output logic [TIMING_W-1:0] vdend_o,
    output logic                scl_o,
    output logic                sda_o,
    output logic                recalc_o
);

    localparam logic [TIMING_W-1:0] HI_V = TIMING_W'(HI_OFS);
    localparam logic [TIMING_W-1:0] LS_V = TIMING_W'(LS_OFS);

    logic [NUM_EXT-1:0]               ext_bits;
    logic                             large_bit;
    logic [NUM_EXT-1:0][TIMING_W-1:0] base_vec, adj_vec;

    assign base_vec[CH_VTOTAL] = vtotal_base_i;
    assign base_vec[CH_VBLANK] = vblank_base_i;
    assign base_vec[CH_VSYNC]  = vsync_base_i;
    assign base_vec[CH_HDEND]  = hdend_base_i;
    assign base_vec[CH_VDEND]  = vdend_base_i;

    crtcx_regfile #(
        .IDX_W(IDX_W), .DATA_W(DATA_W),
        .IDX_PIX(IDX_PIX), .IDX_LARGE(IDX_LARGE), .IDX_GPIO(IDX_GPIO),
        .BIT_VTOTAL(BIT_VTOTAL), .BIT_VDEND(BIT_VDEND), .BIT_VBLANK(BIT_VBLANK),
        .BIT_VSYNC(BIT_VSYNC), .BIT_HDEND(BIT_HDEND), .BIT_LARGE(0),
        .BIT_SCL(BIT_SCL), .BIT_SDA(BIT_SDA)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .ext_o(ext_bits), .large_o(large_bit),
        .scl_o(scl_o), .sda_o(sda_o)
    );

    crtcx_recalc_fsm #(
        .IDX_W(IDX_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
    ) u_recalc (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .recalc_o(recalc_o)
    );

    crtcx_timing_adj #(
        .TIMING_W(TIMING_W), .HI_OFS(HI_OFS), .LS_OFS(LS_OFS)
    ) u_adj (
        .base_i(base_vec), .ext_i(ext_bits), .large_i(large_bit),
        .adj_o(adj_vec)
    );

    assign vtotal_o = adj_vec[CH_VTOTAL];
    assign vblank_o = adj_vec[CH_VBLANK];
    assign vsync_o  = adj_vec[CH_VSYNC];
    assign hdend_o  = adj_vec[CH_HDEND];
    assign vdend_o  = adj_vec[CH_VDEND];

    // R1: after a pixel-mode write, vertical total carries the written bit's offset
    assert_vtotal_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i == IDX_PIX) |=>
            (!$stable(vtotal_base_i) ||
             vtotal_o == vtotal_base_i + ($past(wr_data_i[BIT_VTOTAL]) ? HI_V : '0)));

    // R5: vertical display end only departs from its base while its bit is stored
    assert_vdend_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vdend_o != vdend_base_i) |-> ext_bits[CH_VDEND]);

    // R6: with the horizontal bit clear, only the large-screen offset can appear
    assert_hdend_large_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_bits[CH_HDEND] && large_bit) |-> (hdend_o == hdend_base_i + LS_V));

    // R11: writes to unmapped indices leave the serial lines alone
    assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i != IDX_PIX && wr_idx_i != IDX_LARGE && wr_idx_i != IDX_GPIO)
            |=> $stable(scl_o) && $stable(sda_o));

endmodule

// File: tb/tb_crtcx_ext_top.sv
`timescale 1ns/1ps
module tb_crtcx_ext_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [11:0] b_vt = 12'h20D, b_vb = 12'h1E8, b_vs = 12'h1EA, b_hd = 12'h27F, b_vd = 12'h1DF;
    logic [11:0] o_vt, o_vb, o_vs, o_hd, o_vd;
    logic        scl, sda, recalc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    crtcx_ext_top dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .vtotal_base_i(b_vt), .vblank_base_i(b_vb), .vsync_base_i(b_vs),
        .hdend_base_i(b_hd), .vdend_base_i(b_vd),
        .vtotal_o(o_vt), .vblank_o(o_vb), .vsync_o(o_vs), .hdend_o(o_hd), .vdend_o(o_vd),
        .scl_o(scl), .sda_o(sda), .recalc_o(recalc)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one-cycle write; returns at the falling edge after the capturing edge
    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected timing outputs from a pixel-mode byte and large-screen bit
    task automatic chk_timing(input string req, input logic [7:0] pm, input logic ls);
        chk({req, " vtotal"}, o_vt, b_vt + (pm[0] ? 12'h400 : 12'h0));
        chk({req, " vdend"},  o_vd, b_vd + (pm[1] ? 12'h400 : 12'h0));
        chk({req, " vblank"}, o_vb, b_vb + (pm[2] ? 12'h400 : 12'h0));
        chk({req, " vsync"},  o_vs, b_vs + (pm[3] ? 12'h400 : 12'h0));
        chk({req, " hdend"},  o_hd, b_hd + (pm[4] ? 12'h400 : 12'h0) + (ls ? 12'h100 : 12'h0));
    endtask

    task automatic t_reset;
        chk_timing("R9", 8'h00, 1'b0);
        chk("R9 scl", scl, 0);
        chk("R9 sda", sda, 0);
        chk("R9 recalc", recalc, 0);
    endtask

    task automatic t_single_bits;
        wr(8'h25, 8'h01); chk_timing("R1", 8'h01, 1'b0); chk("R8 pix pulse", recalc, 1);
        wr(8'h25, 8'h04); chk_timing("R2", 8'h04, 1'b0);
        wr(8'h25, 8'h08); chk_timing("R3", 8'h08, 1'b0);
        wr(8'h25, 8'h10); chk_timing("R4", 8'h10, 1'b0);
        wr(8'h25, 8'h02); chk_timing("R5", 8'h02, 1'b0);
        wr(8'h25, 8'hE0); chk_timing("R10 upper bits", 8'h00, 1'b0);
    endtask

    task automatic t_large;
        wr(8'h2D, 8'h01); chk_timing("R6 alone", 8'h00, 1'b1);
        wr(8'h25, 8'h10); chk_timing("R6 with R4", 8'h10, 1'b1);
        wr(8'h2D, 8'hFE); chk_timing("R6 other bits", 8'h10, 1'b0);
        wr(8'h25, 8'h00);
    endtask

    task automatic t_repeat;
        wr(8'h25, 8'h1F); chk_timing("R10 first", 8'h1F, 1'b0);
        wr(8'h25, 8'h1F); chk_timing("R10 again", 8'h1F, 1'b0);
        @(negedge clk);
        b_vt = 12'h3FF; b_hd = 12'h100;
        #1 chk_timing("R12 base change", 8'h1F, 1'b0);
        wr(8'h25, 8'h00); chk_timing("R10 clear", 8'h00, 1'b0);
        b_vt = 12'h20D; b_hd = 12'h27F;
    endtask

    task automatic t_gpio;
        wr(8'h3E, 8'h20); chk("R7 scl hi", scl, 1); chk("R7 sda lo", sda, 0);
        wr(8'h3E, 8'h10); chk("R7 scl lo", scl, 0); chk("R7 sda hi", sda, 1);
        wr(8'h3E, 8'h30); chk("R7 both scl", scl, 1); chk("R7 both sda", sda, 1);
        wr(8'h3E, 8'hCF); chk("R7 clr scl", scl, 0); chk("R7 clr sda", sda, 0);
    endtask

    task automatic t_recalc;
        wr(8'h0D, 8'h00); chk("R8 idx 0D", recalc, 1);
        @(negedge clk); chk("R8 one cycle", recalc, 0);
        wr(8'h0E, 8'h00); chk("R8 idx 0E", recalc, 0);
        wr(8'h0F, 8'h00); chk("R8 idx 0F", recalc, 0);
        wr(8'h10, 8'h00); chk("R8 idx 10", recalc, 0);
        wr(8'h11, 8'h00); chk("R8 idx 11", recalc, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 8'h05;
        @(negedge clk); wr_idx = 8'h06;
        chk("R8 b2b first", recalc, 1);
        @(negedge clk); wr_en = 1'b0;
        chk("R8 b2b second", recalc, 1);
        @(negedge clk); chk("R8 b2b end", recalc, 0);
    endtask

    task automatic t_unmapped;
        wr(8'h25, 8'h1F);
        wr(8'h3E, 8'h30);
        wr(8'h0D, 8'h00); wr(8'h26, 8'h00); wr(8'h3F, 8'h00); wr(8'h2C, 8'hFF);
        chk_timing("R11", 8'h1F, 1'b0);
        chk("R11 scl", scl, 1);
        chk("R11 sda", sda, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_large();
        t_repeat();
        t_gpio();
        t_recalc();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule